// File: doc/BRIEF.md
# DMA Engine Reset and Init Sequencer

This block takes a descriptor-driven DMA engine from power-up to a state where commands may be issued. It first holds the engine's reset line asserted for a fixed settle time. It then releases the line and waits the same settle time again. After that it programs the engine's command-queue registers through a simple write port. The write port carries a valid strobe, an address and data, and it stalls on a ready input. The settle time is counted in clock cycles and derived from a clock-frequency parameter, so a fast simulation can shorten it.

Programming follows a fixed script of five writes:
1. The queue end pointer, set to the byte size of a 128-slot queue.
2. The read pointer, set to a magic constant.
3. The write pointer, cleared to zero.
4. The control word.
5. The queue base address, written last.

When the final write is accepted, a one-cycle clear pulse tells the surrounding logic to reset its command index and its in-progress and direction flags. The sequencer then reports ready. If a later readback of the engine's control register returns zero, the whole reset and programming sequence is replayed.

Top module: `dma_init_seq`

## Requirements
- R1: While reset is low, and for exactly SETTLE cycles after reset goes high (SETTLE = CLK_HZ/1000 × SETTLE_MS), `engReset` is 1. SETTLE is 10 with the bench's parameters.
- R2: After `engReset` falls, `wrValid` stays 0 for exactly SETTLE further cycles. It then rises in the next cycle.
- R3: The script writes five registers in this order, as (address, data) pairs:
  - (0x14, 512)
  - (0x1C, 0xEE882266)
  - (0x18, 0)
  - (0x20, 0x30020070), meaning bits 4, 5, 6, 28 and 29 set and bits 19:17 = 1
  - (0x10, `queueBase`)
- R4: While `wrValid` is 1 and `wrReady` is 0, `wrValid`, `wrAddr` and `wrData` hold their values. A write counts as accepted only in a cycle where both are 1.
- R5: `stateClr` is 1 for exactly the one cycle in which the base-address write is accepted, and is 0 at every other time.
- R6: `initDone` is 1 and `busy` is 0 from the cycle after the last write is accepted until a restart. Before that, `busy` is 1 and `initDone` is 0. While `initDone` is 1, `wrValid` and `engReset` are 0.
- R7: When `initDone` is 1 and `ctrlRbValid` is 1 with `ctrlRbData` equal to 0, the next cycle shows `engReset` = 1 and `busy` = 1. The full R1–R3 sequence then runs again.
- R8: A readback with a nonzero value, or any readback while `busy` is 1, has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| queueBase | input | 32 | Command-queue base address written by the last script step |
| ctrlRbValid | input | 1 | A control-register readback value is present |
| ctrlRbData | input | 32 | Control-register readback value |
| wrReady | input | 1 | Register write port accepts the current write |
| engReset | output | 1 | Reset line to the DMA engine, active high |
| wrValid | output | 1 | Register write request |
| wrAddr | output | 8 | Register byte offset of the current write |
| wrData | output | 32 | Data of the current write |
| stateClr | output | 1 | One-cycle pulse that clears command index and flags |
| initDone | output | 1 | Engine reset and programmed |
| busy | output | 1 | Sequence in progress |

## Verification
The sequence is run under three write-port patterns, each compared cycle by cycle with a behavioural model:
- With `wrReady` always high, the run fixes the exact reset and settle lengths and the order of the five writes.
- With `wrReady` low for some cycles mid-script, the run separates holding a write from advancing past it.
- With a replay started by a zero readback, the run shows that the sequence restarts from the reset phase rather than from the writes, and that the base address written is the current `queueBase`.

Readbacks with nonzero data, and zero readbacks issued while busy, are driven to show that neither one disturbs the sequence.

// File: rtl/dma_init_pkg.sv
package dma_init_pkg;

  typedef enum logic [1:0] {
    ST_HOLD   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_PROG   = 2'd2,
    ST_READY  = 2'd3
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntEn;
    logic cntClr;
    logic stepClr;
    logic stepInc;
  } seqStrobe_t;

  localparam int unsigned SCRIPT_LEN   = 5;
  localparam logic [31:0] RD_PTR_MAGIC = 32'hEE88_2266;

  // control word: completion enables, dirty, request size, timeout, id check
  function automatic logic [31:0] ctrlWord(input logic [2:0] reqSizeCode);
    logic [31:0] w;
    w = '0;
    w[4]     = 1'b1;
    w[5]     = 1'b1;
    w[6]     = 1'b1;
    w[19:17] = reqSizeCode;
    w[28]    = 1'b1;
    w[29]    = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/dma_init_datapath.sv
module dma_init_datapath
  import dma_init_pkg::*;
#(
  parameter int unsigned SETTLE_CYC   = 10,
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned SLOT_COUNT   = 128,
  parameter int unsigned SLOT_STRIDE  = 4,
  parameter logic [2:0]  REQ_SIZE     = 3'd1,
  parameter int unsigned OFF_BASE     = 'h10,
  parameter int unsigned OFF_END      = 'h14,
  parameter int unsigned OFF_WRPTR    = 'h18,
  parameter int unsigned OFF_RDPTR    = 'h1C,
  parameter int unsigned OFF_CTRL     = 'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] queueBase,
  input  logic              ctrlRbValid,
  input  logic [DATA_W-1:0] ctrlRbData,
  output logic              cntDone,
  output logic              lastStep,
  output logic              restartReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);

  localparam int unsigned CNT_W  = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam int unsigned STEP_W = $clog2(SCRIPT_LEN);
  localparam int unsigned END_PTR = SLOT_COUNT * SLOT_STRIDE;
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(SETTLE_CYC - 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(SCRIPT_LEN - 1);

  logic [CNT_W-1:0]  settleCnt;
  logic [STEP_W-1:0] stepIdx;

  // settle counter
  generate
    if (SETTLE_CYC > 1) begin : g_cnt
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              settleCnt <= '0;
        else if (strobe.cntClr) settleCnt <= '0;
        else if (strobe.cntEn)  settleCnt <= settleCnt + 1'b1;
      end
      assign cntDone = (settleCnt == CNT_LAST);
    end else begin : g_cnt1
      assign settleCnt = '0;
      assign cntDone   = 1'b1;
    end
  endgenerate

  // script step index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               stepIdx <= '0;
    else if (strobe.stepClr) stepIdx <= '0;
    else if (strobe.stepInc) stepIdx <= stepIdx + 1'b1;
  end

  assign lastStep = (stepIdx == STEP_LAST);

  // script lookup: order is end, read, write pointer, control, base
  always_comb begin
    unique case (stepIdx)
      STEP_W'(0): begin
        wrAddr = ADDR_W'(OFF_END);
        wrData = DATA_W'(END_PTR);
      end
      STEP_W'(1): begin
        wrAddr = ADDR_W'(OFF_RDPTR);
        wrData = DATA_W'(RD_PTR_MAGIC);
      end
      STEP_W'(2): begin
        wrAddr = ADDR_W'(OFF_WRPTR);
        wrData = '0;
      end
      STEP_W'(3): begin
        wrAddr = ADDR_W'(OFF_CTRL);
        wrData = DATA_W'(ctrlWord(REQ_SIZE));
      end
      default: begin
        wrAddr = ADDR_W'(OFF_BASE);
        wrData = queueBase;
      end
    endcase
  end

  assign restartReq = ctrlRbValid && (ctrlRbData == '0);

endmodule

// File: rtl/dma_init_ctrl.sv
module dma_init_ctrl
  import dma_init_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cntDone,
  input  logic       lastStep,
  input  logic       wrReady,
  input  logic       restartReq,
  output seqStrobe_t strobe,
  output logic       engReset,
  output logic       wrValid,
  output logic       stateClr,
  output logic       initDone,
  output logic       busy
);

  seqState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HOLD;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    stateClr  = 1'b0;
    unique case (state)
      ST_HOLD: begin
        strobe.cntEn = 1'b1;
        if (cntDone) begin
          strobe.cntClr = 1'b1;
          stateNext     = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        strobe.cntEn = 1'b1;
        if (cntDone) begin
          strobe.cntClr  = 1'b1;
          strobe.stepClr = 1'b1;
          stateNext      = ST_PROG;
        end
      end
      ST_PROG: begin
        if (wrReady) begin
          if (lastStep) begin
            stateClr  = 1'b1;
            stateNext = ST_READY;
          end else begin
            strobe.stepInc = 1'b1;
          end
        end
      end
      default: begin
        if (restartReq) begin
          strobe.cntClr = 1'b1;
          stateNext     = ST_HOLD;
        end
      end
    endcase
  end

  assign engReset = (state == ST_HOLD);
  assign wrValid  = (state == ST_PROG);
  assign initDone = (state == ST_READY);
  assign busy     = (state != ST_READY);

endmodule

// File: rtl/dma_init_seq.sv
module dma_init_seq
  import dma_init_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned SETTLE_MS  = 10,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SLOT_COUNT = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] queueBase,
  input  logic              ctrlRbValid,
  input  logic [DATA_W-1:0] ctrlRbData,
  input  logic              wrReady,
  output logic              engReset,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              stateClr,
  output logic              initDone,
  output logic              busy
);

  localparam int unsigned RAW_CYC    = (CLK_HZ / 1000) * SETTLE_MS;
  localparam int unsigned SETTLE_CYC = (RAW_CYC > 0) ? RAW_CYC : 1;

  seqStrobe_t strobe;
  logic cntDone, lastStep, restartReq;

  dma_init_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cntDone    (cntDone),
    .lastStep   (lastStep),
    .wrReady    (wrReady),
    .restartReq (restartReq),
    .strobe     (strobe),
    .engReset   (engReset),
    .wrValid    (wrValid),
    .stateClr   (stateClr),
    .initDone   (initDone),
    .busy       (busy)
  );

  dma_init_datapath #(
    .SETTLE_CYC (SETTLE_CYC),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .SLOT_COUNT (SLOT_COUNT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .queueBase   (queueBase),
    .ctrlRbValid (ctrlRbValid),
    .ctrlRbData  (ctrlRbData),
    .cntDone     (cntDone),
    .lastStep    (lastStep),
    .restartReq  (restartReq),
    .wrAddr      (wrAddr),
    .wrData      (wrData)
  );

endmodule

// File: rtl/dma_init_seq_chk.sv
module dma_init_seq_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctrlRbValid,
  input logic [DATA_W-1:0] ctrlRbData,
  input logic              wrReady,
  input logic              engReset,
  input logic              wrValid,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              stateClr,
  input logic              initDone,
  input logic              busy
);

  a_r2_no_write_in_reset: assert property (@(posedge clk) disable iff (!rstN)
    engReset |-> !wrValid);

  a_r2_release_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $fell(engReset) |-> busy && !wrValid);

  a_r4_hold_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> wrValid && $stable(wrAddr) && $stable(wrData));

  a_r5_clr_on_base: assert property (@(posedge clk) disable iff (!rstN)
    stateClr |-> wrValid && wrReady && (wrAddr == ADDR_W'('h10)));

  a_r5_done_after_clr: assert property (@(posedge clk) disable iff (!rstN)
    stateClr |=> initDone && !stateClr);

  a_r6_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> !wrValid && !engReset && !busy);

  a_r7_restart: assert property (@(posedge clk) disable iff (!rstN)
    (initDone && ctrlRbValid && ctrlRbData == '0) |=> engReset && busy);

  a_r8_nonzero_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (initDone && !(ctrlRbValid && ctrlRbData == '0)) |=> initDone);

endmodule

bind dma_init_seq dma_init_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .ctrlRbValid (ctrlRbValid),
  .ctrlRbData  (ctrlRbData),
  .wrReady     (wrReady),
  .engReset    (engReset),
  .wrValid     (wrValid),
  .wrAddr      (wrAddr),
  .wrData      (wrData),
  .stateClr    (stateClr),
  .initDone    (initDone),
  .busy        (busy)
);

// File: tb/tb_dma_init_seq.sv
module tb_dma_init_seq;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 10;   // 1000 Hz * 10 ms

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] queueBase = 32'h8F80_0000;
  logic        ctrlRbValid = 1'b0;
  logic [31:0] ctrlRbData = '0;
  logic        wrReady = 1'b1;
  logic        engReset, wrValid, stateClr, initDone, busy;
  logic [7:0]  wrAddr;
  logic [31:0] wrData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit cmpOn = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_init_seq #(.CLK_HZ(1000), .SETTLE_MS(10)) dut (
    .clk(clk), .rstN(rstN), .queueBase(queueBase),
    .ctrlRbValid(ctrlRbValid), .ctrlRbData(ctrlRbData), .wrReady(wrReady),
    .engReset(engReset), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .stateClr(stateClr), .initDone(initDone), .busy(busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 reset, 1 settle, 2 writes, 3 ready
  int mPhase = 0;
  int mCnt = 0;
  int mIdx = 0;

  function automatic logic [7:0] expAddr(input int i);
    case (i)
      0: return 8'h14;
      1: return 8'h1C;
      2: return 8'h18;
      3: return 8'h20;
      default: return 8'h10;
    endcase
  endfunction

  function automatic logic [31:0] expData(input int i);
    case (i)
      0: return 32'd512;
      1: return 32'hEE88_2266;
      2: return 32'd0;
      3: return 32'h3002_0070;
      default: return queueBase;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mIdx = 0;
    end else begin
      case (mPhase)
        0: if (mCnt == SETTLE-1) begin mPhase = 1; mCnt = 0; end else mCnt++;
        1: if (mCnt == SETTLE-1) begin mPhase = 2; mCnt = 0; mIdx = 0; end else mCnt++;
        2: if (wrReady) begin if (mIdx == 4) mPhase = 3; else mIdx++; end
        default: if (ctrlRbValid && ctrlRbData == 0) begin mPhase = 0; mCnt = 0; end
      endcase
    end
  end

  // per-cycle compare, away from the active edge
  always @(negedge clk) begin
    #1;
    if (cmpOn) begin
      check("R1 engReset", engReset, mPhase == 0);
      check("R2 wrValid", wrValid, mPhase == 2);
      if (mPhase == 2) begin
        check("R3 wrAddr", wrAddr, expAddr(mIdx));
        check("R3 wrData", wrData, expData(mIdx));
      end
      check("R5 stateClr", stateClr, (mPhase == 2) && (mIdx == 4) && wrReady);
      check("R6 initDone", initDone, mPhase == 3);
      check("R6 busy", busy, mPhase != 3);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    cmpOn = 1;
    cyc(3);
    #2;
    check("R1 reset engReset", engReset, 1);
    check("R6 reset busy", busy, 1);
    check("R2 reset wrValid", wrValid, 0);
    rstN = 1'b1;

    // pass 1: port always ready; count reset and settle lengths
    begin
      int hi = 0;
      int gap = 0;
      while (engReset) begin cyc(1); #2; hi++; end
      while (!wrValid && !initDone) begin cyc(1); #2; gap++; end
      check("R1 reset length", hi, SETTLE);
      check("R2 settle gap", gap, SETTLE);
    end
    while (!initDone) cyc(1);
    cyc(2);

    // R8: nonzero readback while ready
    ctrlRbValid = 1; ctrlRbData = 32'h0000_0010;
    cyc(1);
    ctrlRbValid = 0;
    cyc(1); #2;
    check("R8 nonzero ignored", initDone, 1);

    // R7: zero readback restarts
    queueBase = 32'h9C00_1000;
    ctrlRbValid = 1; ctrlRbData = 0;
    cyc(1);
    ctrlRbValid = 0;
    #2;
    check("R7 restart engReset", engReset, 1);
    check("R7 restart busy", busy, 1);

    // R8: zero readback while busy is ignored
    cyc(3);
    ctrlRbValid = 1; ctrlRbData = 0;
    cyc(1);
    ctrlRbValid = 0;
    // pass 2: stalls during writes
    while (!wrValid) cyc(1);
    wrReady = 0;
    cyc(1);
    begin
      logic [7:0] a0;
      a0 = wrAddr;
      cyc(2); #2;
      check("R4 stall holds addr", wrAddr, a0);
      check("R4 stall holds valid", wrValid, 1);
    end
    for (int i = 0; i < 12; i++) begin
      wrReady = (i % 3) != 0;
      cyc(1);
    end
    wrReady = 1;
    while (!initDone) cyc(1);
    cyc(2); #2;
    check("R6 done after replay", initDone, 1);
    check("R6 not busy", busy, 0);
    cyc(2);
    summary();
  end

endmodule